// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor's byte-wide load/store port and a block-wide memory port. Each request is split into a tag, a set index and a byte offset. The set index chooses one set of two lines, and both stored tags are compared against the request tag. A hit completes without any memory traffic.

A miss refills the block from memory. An invalid line in the set is used first; otherwise the victim is the least-recently-used line, tracked by one bit per set. Writes are write-back. A write marks its line as modified and never goes to memory directly. A modified victim is written back in full before the refill of that line is requested. A write miss allocates the line, then merges the byte into the refilled block.

The set-index width is a parameter. The default keeps storage small, and setting it to 13 gives the 8K-set arrangement with a 9-bit tag for a 24-bit address. Memory transfers use a request/acknowledge handshake: the cache holds a request until the memory acknowledges it for one cycle.

Top module: `cache_2way_wb`

## Requirements
- R1: An address splits into the byte offset in bits [1:0], the set index in bits [SET_W+1:2] and the tag in the bits above. Two blocks whose addresses differ only in the tag share a set and can be resident together.
- R2: A read that hits returns, in its completion cycle, the byte at lane `offset` of the stored block (lane n is bits [8n+7:8n]), and issues no memory transaction.
- R3: A write that hits updates only that byte of the line, marks the line modified, and issues no memory transaction; later reads return the new byte.
- R4: On a miss, an invalid line of the set is refilled in preference to evicting a valid one (line 0 before line 1).
- R5: With both lines valid, a miss replaces the line of the set not used by the most recent hit or refill in that set.
- R6: Evicting a modified line issues exactly one block write of its own address and contents, completed before the refill read starts. Evicting an unmodified line issues no write.
- R7: A write miss refills the block from memory, merges the written byte, and leaves the line modified.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged into the next cycle.
- R9: Each accepted request produces exactly one single-cycle `cpu_done` pulse, with no memory request in that cycle.
- R10: Reset invalidates every line, so the first access to any address afterwards misses; `cpu_done` and `mem_req` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block refill |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 32 | Write-back block |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 32 | Refill block, valid with `mem_ack` |

## Verification
The bound checker watches the port-level protocol on every cycle. It checks that memory requests stay stable until acknowledged, that a write-back is followed by a refill of the same set, and that the completion pulse is one cycle long and never overlaps a memory request. Which line is chosen as victim, whether a hit really avoids memory, and whether modified data survives eviction and comes back on a later miss can only be shown by the bench. The bench does this with conflict sequences inside single sets, compared against a reference byte memory and per-access counts of refills and write-backs.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_LOOK,
    CS_WBACK,
    CS_FILL,
    CS_RESP
  } cstate_t;
  localparam int NWAYS = 2;
endpackage

// File: rtl/c2w_rst_sync.sv
module c2w_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/c2w_way.sv
module c2w_way #(
  parameter int SET_W = 8,
  parameter int TAG_W = 14,
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             wr_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_blk
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [BLK_W-1:0] blk_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
      dirty_q[wr_set] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set] <= wr_tag;
      blk_mem[wr_set] <= wr_blk;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_mem[rd_set];
  assign rd_blk   = blk_mem[rd_set];
endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             used_way,
  output logic             lru_way
);
  localparam int SETS = 1 << SET_W;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (upd_en) lru_q[upd_set] <= ~used_way;
  end

  assign lru_way = lru_q[rd_set];
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
  import c2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 8,
  parameter int TAG_W  = ADDR_W - SET_W - OFF_W,
  parameter int BLK_W  = BYTE_W << OFF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [BYTE_W-1:0]           cpu_wdata,
  output logic                        cpu_done,
  output logic [BYTE_W-1:0]           cpu_rdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [BLK_W-1:0]            mem_wdata,
  input  logic                        mem_ack,
  input  logic [BLK_W-1:0]            mem_rdata,
  input  logic [NWAYS-1:0]            way_valid,
  input  logic [NWAYS-1:0]            way_dirty,
  input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [NWAYS-1:0][BLK_W-1:0] way_blk,
  input  logic                        lru_way,
  output logic [SET_W-1:0]            acc_set,
  output logic [NWAYS-1:0]            way_wr_en,
  output logic [TAG_W-1:0]            wr_tag,
  output logic [BLK_W-1:0]            wr_blk,
  output logic                        wr_dirty,
  output logic                        lru_upd,
  output logic                        lru_used
);
  cstate_t              state_q, state_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic                 we_q, we_d;
  logic [BYTE_W-1:0]    wdata_q, wdata_d;
  logic                 vic_q, vic_d;
  logic [BYTE_W-1:0]    rdata_q, rdata_d;

  logic [TAG_W-1:0]     tag_q;
  logic [SET_W-1:0]     set_q;
  logic [OFF_W-1:0]     off_q;
  logic [NWAYS-1:0]     hit_vec;
  logic                 hit_way;
  logic                 victim_sel;

  assign off_q = addr_q[OFF_W-1:0];
  assign set_q = addr_q[OFF_W +: SET_W];
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];
  assign acc_set = set_q;
  assign wr_tag  = tag_q;

  function automatic logic [BLK_W-1:0] merge_byte(input logic [BLK_W-1:0] blk,
                                                   input logic [OFF_W-1:0] lane,
                                                   input logic [BYTE_W-1:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[lane*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [BLK_W-1:0] blk,
                                                   input logic [OFF_W-1:0] lane);
    return blk[lane*BYTE_W +: BYTE_W];
  endfunction

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag_q);
  end
  assign hit_way = hit_vec[1];

  always_comb begin
    if (!way_valid[0])      victim_sel = 1'b0;
    else if (!way_valid[1]) victim_sel = 1'b1;
    else                    victim_sel = lru_way;
  end

  // next-state process
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    we_d      = we_q;
    wdata_d   = wdata_q;
    vic_d     = vic_q;
    rdata_d   = rdata_q;
    way_wr_en = '0;
    wr_blk    = way_blk[hit_way];
    wr_dirty  = 1'b0;
    lru_upd   = 1'b0;
    lru_used  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {tag_q, set_q, {OFF_W{1'b0}}};
    mem_wdata = way_blk[vic_q];
    unique case (state_q)
      CS_IDLE: begin
        if (cpu_req) begin
          addr_d  = cpu_addr;
          we_d    = cpu_we;
          wdata_d = cpu_wdata;
          state_d = CS_LOOK;
        end
      end
      CS_LOOK: begin
        if (|hit_vec) begin
          lru_upd  = 1'b1;
          lru_used = hit_way;
          rdata_d  = pick_byte(way_blk[hit_way], off_q);
          if (we_q) begin
            way_wr_en[hit_way] = 1'b1;
            wr_blk   = merge_byte(way_blk[hit_way], off_q, wdata_q);
            wr_dirty = 1'b1;
          end
          state_d = CS_RESP;
        end else begin
          vic_d = victim_sel;
          if (way_valid[victim_sel] && way_dirty[victim_sel]) state_d = CS_WBACK;
          else                                                state_d = CS_FILL;
        end
      end
      CS_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {way_tag[vic_q], set_q, {OFF_W{1'b0}}};
        if (mem_ack) state_d = CS_FILL;
      end
      CS_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          way_wr_en[vic_q] = 1'b1;
          wr_blk   = we_q ? merge_byte(mem_rdata, off_q, wdata_q) : mem_rdata;
          wr_dirty = we_q;
          lru_upd  = 1'b1;
          lru_used = vic_q;
          rdata_d  = pick_byte(mem_rdata, off_q);
          state_d  = CS_RESP;
        end
      end
      CS_RESP: state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      vic_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      vic_q   <= vic_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_done  = (state_q == CS_RESP);
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_2way_wb.sv
module cache_2way_wb
  import c2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 8,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int BLK_W = BYTE_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_rdata
);
  logic                        rst_n_i;
  logic [NWAYS-1:0]            way_valid;
  logic [NWAYS-1:0]            way_dirty;
  logic [NWAYS-1:0][TAG_W-1:0] way_tag;
  logic [NWAYS-1:0][BLK_W-1:0] way_blk;
  logic [NWAYS-1:0]            way_wr_en;
  logic [SET_W-1:0]            acc_set;
  logic [TAG_W-1:0]            wr_tag;
  logic [BLK_W-1:0]            wr_blk;
  logic                        wr_dirty;
  logic                        lru_way;
  logic                        lru_upd;
  logic                        lru_used;

  c2w_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    c2w_way #(.SET_W(SET_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .rd_set   (acc_set),
      .wr_en    (way_wr_en[w]),
      .wr_set   (acc_set),
      .wr_tag   (wr_tag),
      .wr_blk   (wr_blk),
      .wr_dirty (wr_dirty),
      .rd_valid (way_valid[w]),
      .rd_dirty (way_dirty[w]),
      .rd_tag   (way_tag[w]),
      .rd_blk   (way_blk[w])
    );
  end

  c2w_lru #(.SET_W(SET_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .rd_set   (acc_set),
    .upd_en   (lru_upd),
    .upd_set  (acc_set),
    .used_way (lru_used),
    .lru_way  (lru_way)
  );

  c2w_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_done  (cpu_done),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .way_valid (way_valid),
    .way_dirty (way_dirty),
    .way_tag   (way_tag),
    .way_blk   (way_blk),
    .lru_way   (lru_way),
    .acc_set   (acc_set),
    .way_wr_en (way_wr_en),
    .wr_tag    (wr_tag),
    .wr_blk    (wr_blk),
    .wr_dirty  (wr_dirty),
    .lru_upd   (lru_upd),
    .lru_used  (lru_used)
  );
endmodule

// File: rtl/c2w_chk.sv
module c2w_chk #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R6
  wb_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=>
      (mem_addr[OFF_W +: SET_W] == $past(mem_addr[OFF_W +: SET_W])));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !mem_req);
endmodule

bind cache_2way_wb c2w_chk #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_done (cpu_done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack)
);

// File: tb/sim_cache_2way_wb.sv
module sim_cache_2way_wb;
  localparam int PERIOD = 10;
  localparam int NVEC   = 16;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [23:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_done;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int n_fill  = 0;
  int n_wb    = 0;
  int n_unstable = 0;
  int hold_cnt = 0;
  logic [23:0] hold_addr;
  bit op_hist[$];

  logic [31:0] bmem [int];
  logic [7:0]  gmem [int];

  cache_2way_wb u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] init_blk(input int b);
    return b * 32'h9E3779B1 + 32'h13572468;
  endfunction

  function automatic logic [31:0] mem_blk(input int b);
    if (bmem.exists(b)) return bmem[b];
    return init_blk(b);
  endfunction

  function automatic logic [7:0] gold_byte(input logic [23:0] a);
    logic [31:0] blk;
    if (gmem.exists(int'(a))) return gmem[int'(a)];
    blk = init_blk(int'(a >> 2));
    return blk[a[1:0]*8 +: 8];
  endfunction

  // memory responder: acknowledges each request after a short wait
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      hold_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack  <= 1'b0;
      hold_cnt <= 0;
      if (mem_addr !== hold_addr) n_unstable++;
      op_hist.push_back(mem_we);
      if (mem_we) begin
        bmem[int'(mem_addr >> 2)] = mem_wdata;
        n_wb++;
      end else begin
        n_fill++;
      end
    end else if (mem_req) begin
      if (hold_cnt == 0) hold_addr <= mem_addr;
      else if (mem_addr !== hold_addr) n_unstable++;
      if (hold_cnt == 2) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_blk(int'(mem_addr >> 2));
      end
      hold_cnt <= hold_cnt + 1;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [23:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int nf, output int nw,
                        output logic order_ok);
    int f0, w0, h0, guard;
    f0 = n_fill; w0 = n_wb; h0 = op_hist.size();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cpu_done && guard < 200);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    nf = n_fill - f0;
    nw = n_wb - w0;
    order_ok = (nw == 0) || (op_hist[h0] == 1'b1);
    check("R9 completion seen", {31'd0, cpu_done}, 32'd1);
    @(negedge clk);
    check("R9 done lasts one cycle", {31'd0, cpu_done}, 32'd0);
    if (we) gmem[int'(a)] = d;
  endtask

  // {we, addr, wdata, expected refills, expected write-backs}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 24'h000001, 8'h00, 2'd1, 2'd0},
    {1'b0, 24'h000003, 8'h00, 2'd0, 2'd0},
    {1'b1, 24'h000002, 8'h5A, 2'd0, 2'd0},
    {1'b0, 24'h000400, 8'h00, 2'd1, 2'd0},
    {1'b0, 24'h000002, 8'h00, 2'd0, 2'd0},
    {1'b0, 24'h00A000, 8'h00, 2'd1, 2'd0},
    {1'b0, 24'h000800, 8'h00, 2'd1, 2'd1},
    {1'b0, 24'h000002, 8'h00, 2'd1, 2'd0},
    {1'b1, 24'h000805, 8'hC3, 2'd1, 2'd0},
    {1'b0, 24'h000805, 8'h00, 2'd0, 2'd0},
    {1'b1, 24'h000C06, 8'h11, 2'd1, 2'd0},
    {1'b0, 24'h000404, 8'h00, 2'd1, 2'd1},
    {1'b0, 24'h000806, 8'h00, 2'd1, 2'd1},
    {1'b0, 24'h000805, 8'h00, 2'd0, 2'd0},
    {1'b1, 24'hFFFFFF, 8'hEE, 2'd1, 2'd0},
    {1'b0, 24'hFFFFFF, 8'h00, 2'd0, 2'd0}
  };

  initial begin
    logic [7:0] rd;
    logic [7:0] exp_rd;
    int nf, nw;
    logic ok;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs in reset
    check("R10 cpu_done in reset", {31'd0, cpu_done}, 32'd0);
    check("R10 mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      exp_rd = gold_byte(VEC[i][35:12]);
      access(VEC[i][36], VEC[i][35:12], VEC[i][11:4], rd, nf, nw, ok);
      check($sformatf("R4/R5/R7 refill count, vector %0d", i), nf, {30'd0, VEC[i][3:2]});
      check($sformatf("R6 write-back count, vector %0d", i), nw, {30'd0, VEC[i][1:0]});
      check($sformatf("R6 write-back before refill, vector %0d", i), {31'd0, ok}, 32'd1);
      if (!VEC[i][36])
        check($sformatf("R1/R2/R3 read byte, vector %0d", i), {24'd0, rd}, {24'd0, exp_rd});
    end

    // R6: modified block 0 was written back with its merged byte
    check("R6 evicted dirty data in memory", {31'd0, bmem.exists(0)}, 32'd1);
    if (bmem.exists(0)) check("R6 written-back byte", {24'd0, bmem[0][23:16]}, 32'h5A);
    // R6: clean block at 0x400 was never written back
    check("R6 clean eviction left memory untouched", {31'd0, bmem.exists(24'h000400 >> 2)}, 32'd0);
    // R8: requests held steady until acknowledged
    check("R8 request stability", n_unstable, 32'd0);

    // R10: reset again; a resident line must miss afterwards
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_rd = gold_byte(24'h000805);
    access(1'b0, 24'h000805, 8'h00, rd, nf, nw, ok);
    check("R10 line invalid after reset", nf, 32'd1);
    check("R10 data after reset from memory", {24'd0, rd}, {24'd0, exp_rd});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule